// File: doc/BRIEF.md
# Packed Saturating Add and Absolute-Value Unit

This block is the arithmetic core for packed small-integer work inside a processor datapath. It takes two 32-bit source operands and treats them, depending on the selected operation, as four byte lanes, two halfword lanes or a single word. It computes absolute values and additions lane by lane, each lane clamping on its own, and it returns the packed result combinationally in the same cycle.

Two status bits sit beside the datapath: a sticky overflow bit and a carry bit. Every lane of every operation that saturates, overflows or underflows sets the overflow bit. A dedicated word add stores its carry-out, and a second word add consumes that carry. Together these two adds build a 64-bit addition from two 32-bit halves. The status bits change only on a clock edge on which the write enable is high.

Top module: `pack_sat_alu`

## Requirements
- R1: Opcode encoding on `op_sel`: 0 abs bytes, 1 abs halfwords, 2 abs word, 3 signed halfword add wrapping, 4 signed halfword add saturating, 5 signed word add saturating, 6 unsigned byte add wrapping, 7 unsigned byte add saturating, 8 unsigned halfword add wrapping, 9 unsigned halfword add saturating, 10 word add recording carry, 11 word add consuming carry; codes 12 to 15 are unused.
- R2: Absolute value (of `rt`) turns a lane holding the most negative value (0x80, 0x8000, 0x80000000) into the largest positive value (0x7F, 0x7FFF, 0x7FFFFFFF) and counts that as an overflow event.
- R3: Absolute value negates every other negative lane and passes non-negative lanes unchanged, with no overflow event.
- R4: Signed saturating add clamps a lane whose sign-extended sum overflows to the positive maximum, and one that underflows to the negative minimum, and flags the event.
- R5: The wrapping adds (signed halfword, unsigned byte, unsigned halfword) write each lane modulo 2^width but still raise the overflow event for a lane that overflows.
- R6: Unsigned saturating add clamps a lane whose zero-extended sum carries out to all ones (0xFF or 0xFFFF) and flags it.
- R7: Lanes are packed most significant element first: byte lane k sits at bits [8k+7:8k], halfword lane k at [16k+15:16k], with lane results independent of one another.
- R8: An overflow event with `wr_en` high sets `ovf_flag` at the next clock edge. Nothing but reset clears it, and without `wr_en` it does not change.
- R9: Opcode 10 writes the low 32 bits of the zero-extended sum `rs+rt` and loads its bit 32 into `carry_flag` when `wr_en` is high. It never sets `ovf_flag`.
- R10: Opcode 11 writes `rs+rt+carry_flag` computed in sign-extended 33-bit arithmetic. It flags overflow when sum bits 32 and 31 differ and leaves `carry_flag` unchanged.
- R11: Unused opcodes give a zero result and change neither flag.
- R12: Synchronous active-high reset clears both `ovf_flag` and `carry_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation select, encoding in R1 |
| rs | input | 32 | First source operand |
| rt | input | 32 | Second source operand (sole operand of absolute value) |
| wr_en | input | 1 | Allows the status bits to update at the clock edge |
| result | output | 32 | Packed combinational result |
| ovf_flag | output | 1 | Sticky overflow status bit |
| carry_flag | output | 1 | Carry bit recorded by opcode 10 |

## Verification
The two functions that fall in the same cycle are the carry-consuming add and the flag update. On one edge opcode 11 reads `carry_flag` and may also set the sticky overflow bit, while `carry_flag` itself must hold. The bench first records a carry with opcode 10 and then runs opcode 11 on operands whose result only comes out right if that carry is folded in. It then confirms at the next low clock phase that the carry bit kept its value and that the overflow bit reflects only the signed sum. A second pairing is the carry-recording add on operands that overflow as signed numbers: the bench checks that the carry updates while the overflow bit stays clear.

// File: rtl/pksat_pkg.sv
package pksat_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ABS_B    = 4'd0,
        OP_ABS_H    = 4'd1,
        OP_ABS_W    = 4'd2,
        OP_SADD_H   = 4'd3,
        OP_SADD_H_S = 4'd4,
        OP_SADD_W_S = 4'd5,
        OP_UADD_B   = 4'd6,
        OP_UADD_B_S = 4'd7,
        OP_UADD_H   = 4'd8,
        OP_UADD_H_S = 4'd9,
        OP_ADD_REC  = 4'd10,
        OP_ADD_CIN  = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic carry;
    } status_t;

    function automatic logic is_op(input logic [OP_W-1:0] code, input alu_op_e which);
        return code == which;
    endfunction

endpackage

// File: rtl/abs_lane.sv
module abs_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        sat = (val == MOST_NEG);
        if (sat)
            res = MOST_POS;
        else if (val[W-1])
            res = ~val + 1'b1;
        else
            res = val;
    end
endmodule

// File: rtl/add_lane.sv
module add_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sat_en,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W:0]   ext_sum;
    logic [W-1:0] clamp;

    generate
        if (SIGNED) begin : g_signed
            assign ext_sum = {a[W-1], a} + {b[W-1], b};
            assign ovf     = ext_sum[W] ^ ext_sum[W-1];
            assign clamp   = ext_sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin : g_unsigned
            assign ext_sum = {1'b0, a} + {1'b0, b};
            assign ovf     = ext_sum[W];
            assign clamp   = '1;
        end
    endgenerate

    assign res = (sat_en && ovf) ? clamp : ext_sum[W-1:0];
endmodule

// File: rtl/carry_add.sv
module carry_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] rec_sum,
    output logic         rec_cout,
    output logic [W-1:0] cin_sum,
    output logic         cin_ovf
);
    logic [W:0] zext_sum;
    logic [W:0] sext_sum;

    assign zext_sum = {1'b0, a} + {1'b0, b};
    assign sext_sum = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, cin};

    assign rec_sum  = zext_sum[W-1:0];
    assign rec_cout = zext_sum[W];
    assign cin_sum  = sext_sum[W-1:0];
    assign cin_ovf  = sext_sum[W] ^ sext_sum[W-1];
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import pksat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  logic    ovf_evt,
    input  logic    carry_we,
    input  logic    carry_d,
    output status_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (we) begin
            if (ovf_evt)
                st.ovf <= 1'b1;
            if (carry_we)
                st.carry <= carry_d;
        end
    end
endmodule

// File: rtl/pack_sat_alu.sv
module pack_sat_alu
    import pksat_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] rs,
    input  logic [DATA_W-1:0] rt,
    input  logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              ovf_flag,
    output logic              carry_flag
);
    localparam int NB = DATA_W / BYTE_W;
    localparam int NH = DATA_W / HALF_W;

    logic [DATA_W-1:0] ab_res, ah_res, aw_res, sh_res, sw_res, ub_res, uh_res;
    logic [DATA_W-1:0] rec_sum, cin_sum;
    logic [NB-1:0]     ab_ovf, ub_ovf;
    logic [NH-1:0]     ah_ovf, sh_ovf, uh_ovf;
    logic              aw_ovf, sw_ovf, rec_cout, cin_ovf;
    logic              ovf_evt;
    status_t           st;

    // byte lanes, most significant element in the top byte
    for (genvar i = 0; i < NB; i++) begin : g_byte
        abs_lane #(.W(BYTE_W)) u_abs (
            .val (rt[i*BYTE_W +: BYTE_W]),
            .res (ab_res[i*BYTE_W +: BYTE_W]),
            .sat (ab_ovf[i])
        );
        add_lane #(.W(BYTE_W), .SIGNED(1'b0)) u_uadd (
            .a      (rs[i*BYTE_W +: BYTE_W]),
            .b      (rt[i*BYTE_W +: BYTE_W]),
            .sat_en (is_op(op_sel, OP_UADD_B_S)),
            .res    (ub_res[i*BYTE_W +: BYTE_W]),
            .ovf    (ub_ovf[i])
        );
    end

    for (genvar j = 0; j < NH; j++) begin : g_half
        abs_lane #(.W(HALF_W)) u_abs (
            .val (rt[j*HALF_W +: HALF_W]),
            .res (ah_res[j*HALF_W +: HALF_W]),
            .sat (ah_ovf[j])
        );
        add_lane #(.W(HALF_W), .SIGNED(1'b1)) u_sadd (
            .a      (rs[j*HALF_W +: HALF_W]),
            .b      (rt[j*HALF_W +: HALF_W]),
            .sat_en (is_op(op_sel, OP_SADD_H_S)),
            .res    (sh_res[j*HALF_W +: HALF_W]),
            .ovf    (sh_ovf[j])
        );
        add_lane #(.W(HALF_W), .SIGNED(1'b0)) u_uadd (
            .a      (rs[j*HALF_W +: HALF_W]),
            .b      (rt[j*HALF_W +: HALF_W]),
            .sat_en (is_op(op_sel, OP_UADD_H_S)),
            .res    (uh_res[j*HALF_W +: HALF_W]),
            .ovf    (uh_ovf[j])
        );
    end

    abs_lane #(.W(DATA_W)) u_abs_w (
        .val (rt),
        .res (aw_res),
        .sat (aw_ovf)
    );

    add_lane #(.W(DATA_W), .SIGNED(1'b1)) u_sadd_w (
        .a      (rs),
        .b      (rt),
        .sat_en (1'b1),
        .res    (sw_res),
        .ovf    (sw_ovf)
    );

    carry_add #(.W(DATA_W)) u_carry (
        .a        (rs),
        .b        (rt),
        .cin      (st.carry),
        .rec_sum  (rec_sum),
        .rec_cout (rec_cout),
        .cin_sum  (cin_sum),
        .cin_ovf  (cin_ovf)
    );

    always_comb begin
        result  = '0;
        ovf_evt = 1'b0;
        case (op_sel)
            OP_ABS_B:    begin result = ab_res;  ovf_evt = |ab_ovf; end
            OP_ABS_H:    begin result = ah_res;  ovf_evt = |ah_ovf; end
            OP_ABS_W:    begin result = aw_res;  ovf_evt = aw_ovf;  end
            OP_SADD_H,
            OP_SADD_H_S: begin result = sh_res;  ovf_evt = |sh_ovf; end
            OP_SADD_W_S: begin result = sw_res;  ovf_evt = sw_ovf;  end
            OP_UADD_B,
            OP_UADD_B_S: begin result = ub_res;  ovf_evt = |ub_ovf; end
            OP_UADD_H,
            OP_UADD_H_S: begin result = uh_res;  ovf_evt = |uh_ovf; end
            OP_ADD_REC:  begin result = rec_sum; end
            OP_ADD_CIN:  begin result = cin_sum; ovf_evt = cin_ovf; end
            default:     begin result = '0;      end
        endcase
    end

    flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .ovf_evt  (ovf_evt),
        .carry_we (is_op(op_sel, OP_ADD_REC)),
        .carry_d  (rec_cout),
        .st       (st)
    );

    assign ovf_flag   = st.ovf;
    assign carry_flag = st.carry;

    AST_STICKY_OVF: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R8
    AST_OVF_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ovf_flag)); // R8
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && op_sel == OP_ADD_REC) |=> $stable(carry_flag)); // R10
    AST_REC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sel == OP_ADD_REC && !ovf_flag) |=> !ovf_flag); // R9
    AST_UNUSED_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_ADD_CIN && !ovf_flag) |=> !ovf_flag); // R11
    AST_ABS_W_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ABS_W) |-> !result[DATA_W-1]); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ovf_flag && !carry_flag)); // R12
endmodule

// File: tb/pack_sat_alu_tb.sv
`timescale 1ns/1ps
module pack_sat_alu_tb;
    import pksat_pkg::*;

    localparam real CLK_PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic [31:0] rs = '0;
    logic [31:0] rt = '0;
    logic        wr_en = 1'b0;
    logic [31:0] result;
    logic        ovf_flag;
    logic        carry_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pack_sat_alu u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .rs(rs), .rt(rt),
        .wr_en(wr_en), .result(result), .ovf_flag(ovf_flag), .carry_flag(carry_flag)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        ovf;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'h0,        32'h807FFF01, 32'h7F7F0101, 1'b1}, // R2 R3 R7
        '{4'd0,  32'h0,        32'hF6008110, 32'h0A007F10, 1'b0}, // R3
        '{4'd1,  32'h0,        32'h8000FFFF, 32'h7FFF0001, 1'b1}, // R2
        '{4'd2,  32'h0,        32'h80000000, 32'h7FFFFFFF, 1'b1}, // R2
        '{4'd2,  32'h0,        32'hFFFFFFFE, 32'h00000002, 1'b0}, // R3
        '{4'd3,  32'h7FFF0001, 32'h00010002, 32'h80000003, 1'b1}, // R5
        '{4'd4,  32'h7FFF0001, 32'h00010002, 32'h7FFF0003, 1'b1}, // R4
        '{4'd4,  32'h80001000, 32'hFFFF2000, 32'h80003000, 1'b1}, // R4
        '{4'd4,  32'h1234F000, 32'h01000FFF, 32'h1334FFFF, 1'b0}, // R4
        '{4'd5,  32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R4
        '{4'd5,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R4
        '{4'd5,  32'h00000005, 32'hFFFFFFFD, 32'h00000002, 1'b0}, // R4
        '{4'd6,  32'hFF108001, 32'h01208002, 32'h00300003, 1'b1}, // R5 R7
        '{4'd7,  32'hFF108001, 32'h01208002, 32'hFF30FF03, 1'b1}, // R6 R7
        '{4'd8,  32'hFFFF1234, 32'h00020001, 32'h00011235, 1'b1}, // R5
        '{4'd9,  32'hFFFF1234, 32'h00020001, 32'hFFFF1235, 1'b1}, // R6
        '{4'd9,  32'h7FFF0000, 32'h80000000, 32'hFFFF0000, 1'b0}, // R6
        '{4'd10, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b0}, // R9
        '{4'd11, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R10
        '{4'd13, 32'h00000001, 32'h00000001, 32'h00000000, 1'b0}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at the low phase, check the result, take one edge, check the flags
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic we, input logic [31:0] exp_res, input string tag);
        @(negedge clk);
        op_sel = op; rs = a; rt = b; wr_en = we;
        #1;
        check(tag, result, exp_res);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // independent behavioural model, carry assumed clear
    function automatic logic [32:0] ref_model(input int op, input logic [31:0] a, input logic [31:0] b);
        int w;
        longint mask, half, ua, ub, sa, sb, s, r;
        logic [31:0] res = '0;
        logic ov = 1'b0;
        case (op)
            0, 6, 7:       w = 8;
            1, 3, 4, 8, 9: w = 16;
            default:       w = 32;
        endcase
        mask = (64'sd1 <<< w) - 1;
        half = 64'sd1 <<< (w - 1);
        if (op <= 9) begin
            for (int l = 0; l < 32 / w; l++) begin
                ua = longint'((a >> (l * w))) & mask;
                ub = longint'((b >> (l * w))) & mask;
                sa = (ua >= half) ? ua - (mask + 1) : ua;
                sb = (ub >= half) ? ub - (mask + 1) : ub;
                if (op <= 2) begin
                    if (sb == -half) begin r = half - 1; ov = 1'b1; end
                    else r = (sb < 0) ? -sb : sb;
                end else if (op <= 5) begin
                    s = sa + sb;
                    r = s;
                    if (s > half - 1) begin ov = 1'b1; if (op != 3) r = half - 1; end
                    if (s < -half)    begin ov = 1'b1; if (op != 3) r = -half; end
                end else begin
                    s = ua + ub;
                    r = s;
                    if (s > mask) begin ov = 1'b1; if (op == 7 || op == 9) r = mask; end
                end
                res = res | 32'((r & mask) << (l * w));
            end
        end else if (op == 10) begin
            res = a + b;
        end else if (op == 11) begin
            s = longint'($signed(a)) + longint'($signed(b));
            res = 32'(s);
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        return {ov, res};
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 5))
            0: return {4{8'h80}};
            1: return {4{8'h7F}};
            2: return {2{16'h8000}};
            3: return {2{16'h7FFF}};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [32:0] rv;
        // R12: reset state
        do_reset();
        check("R12 ovf after reset", {31'd0, ovf_flag}, 32'd0);
        check("R12 carry after reset", {31'd0, carry_flag}, 32'd0);

        // table walk: each vector starts from reset
        for (int i = 0; i < NV; i++) begin
            do_reset();
            apply(VECS[i].op, VECS[i].a, VECS[i].b, 1'b1, VECS[i].exp,
                  $sformatf("R1 vector %0d result", i));
            check($sformatf("R8 vector %0d ovf", i), {31'd0, ovf_flag}, {31'd0, VECS[i].ovf});
        end

        // R9: signed overflow on record add leaves ovf clear, carry 0
        do_reset();
        apply(4'd10, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 32'hFFFFFFFE, "R9 result");
        check("R9 ovf untouched", {31'd0, ovf_flag}, 32'd0);
        check("R9 carry zero", {31'd0, carry_flag}, 32'd0);
        apply(4'd10, 32'hFFFFFFFF, 32'h00000001, 1'b1, 32'h00000000, "R9 result carry");
        check("R9 carry set", {31'd0, carry_flag}, 32'd1);
        // R10: carry folded in, carry held, ovf follows signed sum
        apply(4'd11, 32'h00000000, 32'h00000000, 1'b1, 32'h00000001, "R10 uses carry");
        check("R10 carry held", {31'd0, carry_flag}, 32'd1);
        check("R10 no ovf", {31'd0, ovf_flag}, 32'd0);
        apply(4'd11, 32'h7FFFFFFF, 32'h00000000, 1'b1, 32'h80000000, "R10 ovf with carry");
        check("R10 ovf set", {31'd0, ovf_flag}, 32'd1);
        check("R10 carry still held", {31'd0, carry_flag}, 32'd1);

        // R8: write enable low blocks the update
        do_reset();
        apply(4'd2, 32'h0, 32'h80000000, 1'b0, 32'h7FFFFFFF, "R8 result without we");
        check("R8 no update without we", {31'd0, ovf_flag}, 32'd0);
        // R8: sticky across clean operations
        apply(4'd7, 32'hFF000000, 32'h01000000, 1'b1, 32'hFF000000, "R8 set op");
        apply(4'd6, 32'h01010101, 32'h01010101, 1'b1, 32'h02020202, "R8 clean op");
        check("R8 sticky", {31'd0, ovf_flag}, 32'd1);
        // R11: unused code keeps carry
        apply(4'd10, 32'h80000000, 32'h80000000, 1'b1, 32'h00000000, "R9 carry again");
        apply(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h00000000, "R11 unused zero");
        check("R11 carry kept", {31'd0, carry_flag}, 32'd1);
        // R12: reset mid-run clears both
        do_reset();
        check("R12 ovf cleared", {31'd0, ovf_flag}, 32'd0);
        check("R12 carry cleared", {31'd0, carry_flag}, 32'd0);

        // random and corner operands against the model (R1..R7)
        for (int k = 0; k < 300; k++) begin
            int op;
            logic [31:0] a, b;
            op = $urandom_range(0, 11);
            a = pick_val();
            b = pick_val();
            rv = ref_model(op, a, b);
            do_reset();
            apply(op[3:0], a, b, 1'b1, rv[31:0], $sformatf("R7 random op %0d", op));
            check($sformatf("R8 random op %0d ovf", op), {31'd0, ovf_flag}, {31'd0, rv[32]});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule